// File: doc/BRIEF.md
# Paged Flash Program-and-Verify Sequencer

This block writes a host-supplied byte range into a paged serial flash device that has an internal page buffer. It splits the range at page boundaries and handles each page in turn. A page that is only partly covered by the range is first copied from the array into the device buffer, so the bytes outside the range survive. Every page is then sent through the buffer with a program command that erases the page first. When checking is enabled, the array page is compared against the buffer afterwards. The sequencer reads the device status register after every array operation and waits until the device reports ready.

The host gives a byte offset, a length and a stream of write bytes. Configuration inputs set the page size, the shift that places a page number into the flash address, and the device size. Every device byte passes through a byte-wide SPI master port. Each byte on that port returns one received byte, and a last flag closes the chip-select frame. At the end a one-cycle completion pulse reports a range error, a verify error, and the number of bytes committed to verified or unverified pages.

Top module: `flash_page_writer`

## Requirements
- R1: After reset `req_ready` is 1 and `done`, `spi_tx_valid` and `wr_ready` are 0. Every request ends with `done` high for exactly one cycle, with `req_ready` high in that cycle. A zero-length request completes with count 0 and sends no SPI bytes.
- R2: A request whose offset plus length exceeds `cfg_dev_bytes` is refused. It ends with `done_err_range`=1 and count 0, sends no SPI bytes and consumes no write data.
- R3: The first chunk is the smaller of the length and (page size − in-page offset). Each later chunk starts at offset 0 and is the smaller of the remaining length and the page size.
- R4: Before a chunk shorter than a page, the block sends a buffer-load frame: opcode 0x53, then three address bytes (most significant first) equal to page number shifted left by `cfg_page_shift`, whose low byte is 0. It then polls status. A chunk that covers the whole page gets no load frame.
- R5: Each chunk is written in one program frame: opcode 0x82, three address bytes equal to (page number << shift) + in-page offset, then the chunk's data bytes in stream order. After the request, the flash holds the new bytes in the range and its old bytes elsewhere.
- R6: A status poll is a two-byte frame: opcode 0xD7, then a dummy 0x00 that carries `spi_tx_last`. The byte received for the dummy is the status. Bit 7 = 1 means ready. The poll repeats until ready, and no further array command is issued before then.
- R7: With `cfg_verify`=1, each programmed page is followed by a compare frame: opcode 0x60 plus the page address with low byte 0, then a poll. Status bit 6 set at ready aborts the remaining pages and reports `done_err_verify`=1, with the count of bytes in the pages that passed. With `cfg_verify`=0, no compare frame is sent.
- R8: `wr_ready` is high only during the data phase of a program frame. Every byte accepted on the write stream is the SPI byte sent in that same cycle.
- R9: At most one SPI byte is outstanding. After a byte is accepted, `spi_tx_valid` stays low until `spi_rx_valid` returns its received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_offset | input | AW | Start byte offset in the device |
| req_len | input | AW | Number of bytes to write |
| cfg_page_size | input | PW | Bytes per page (at least 2) |
| cfg_page_shift | input | 5 | Left shift of page number into flash address (at least 8) |
| cfg_dev_bytes | input | AW+1 | Device size in bytes |
| cfg_verify | input | 1 | Enable compare after program |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Write stream byte taken |
| spi_tx_data | output | 8 | Byte to send |
| spi_tx_last | output | 1 | Byte closes the chip-select frame |
| spi_tx_valid | output | 1 | Byte to send present |
| spi_tx_ready | input | 1 | SPI master takes the byte |
| spi_rx_data | input | 8 | Byte received for the last byte sent |
| spi_rx_valid | input | 1 | Received byte present |
| done | output | 1 | One-cycle completion pulse |
| done_err_range | output | 1 | Request refused for range |
| done_err_verify | output | 1 | Compare mismatch aborted the request |
| done_count | output | AW | Bytes committed |

## Verification
The bench keeps the default widths (AW=24, PW=12) and drives an 8-byte page, a shift of 8 and a 4-page, 32-byte device. At that size it can sweep every start offset with lengths that land below, at and across page ends, including the whole device and one byte past its end. Every split into partial and full chunks is therefore reached within a short run. A device model in the bench stays busy for two polls after each array operation and can corrupt a chosen page after programming. This drives the repoll path and the verify abort on the first, middle and last page of a range.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int AW = 24,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_offset,
  input  logic [AW-1:0] req_len,
  input  logic [PW-1:0] cfg_page_size,
  input  logic [4:0]    cfg_page_shift,
  input  logic [AW:0]   cfg_dev_bytes,
  input  logic          cfg_verify,
  input  logic [7:0]    wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [7:0]    spi_tx_data,
  output logic          spi_tx_last,
  output logic          spi_tx_valid,
  input  logic          spi_tx_ready,
  input  logic [7:0]    spi_rx_data,
  input  logic          spi_rx_valid,
  output logic          done,
  output logic          done_err_range,
  output logic          done_err_verify,
  output logic [AW-1:0] done_count
);
  localparam logic [7:0] OPC_LOAD = 8'h53;
  localparam logic [7:0] OPC_PROG = 8'h82;
  localparam logic [7:0] OPC_CMP  = 8'h60;
  localparam logic [7:0] OPC_STAT = 8'hD7;

  typedef enum logic [1:0] {OP_LOAD, OP_PROG, OP_CMP} op_t;
  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_STAT} ph_t;

  logic          busy, waitrx;
  op_t           op;
  ph_t           ph;
  logic [PW-1:0] idx, off, chunk;
  logic [AW-1:0] page, rem, written;

  logic [AW:0]   req_end;
  logic [AW-1:0] psz_w, start_page, rem_after;
  logic [PW-1:0] start_off, avail, first_chunk, next_chunk;
  logic [31:0]   page_base;
  logic [23:0]   flash_addr;
  logic          fire, step, stat_ready, page_ok;

  assign req_end     = {1'b0, req_offset} + {1'b0, req_len};
  assign psz_w       = AW'(cfg_page_size);
  assign start_page  = req_offset / psz_w;
  assign start_off   = PW'(req_offset % psz_w);
  assign avail       = cfg_page_size - start_off;
  assign first_chunk = (req_len > AW'(avail)) ? avail : PW'(req_len);
  assign rem_after   = rem - AW'(chunk);
  assign next_chunk  = (rem_after > psz_w) ? cfg_page_size : PW'(rem_after);

  assign page_base  = 32'(page) << cfg_page_shift;
  assign flash_addr = page_base[23:0] + ((op == OP_PROG) ? 24'(off) : 24'd0);

  assign req_ready    = !busy;
  assign spi_tx_valid = busy && !waitrx && (ph != PH_DATA || wr_valid);
  assign wr_ready     = busy && !waitrx && ph == PH_DATA && spi_tx_ready;
  assign fire         = spi_tx_valid && spi_tx_ready;
  assign step         = busy && waitrx && spi_rx_valid;
  assign stat_ready   = step && ph == PH_STAT && idx[0] && spi_rx_data[7];
  assign page_ok      = stat_ready &&
                        ((op == OP_PROG && !cfg_verify) || (op == OP_CMP && !spi_rx_data[6]));

  always_comb begin
    spi_tx_data = 8'h00;
    spi_tx_last = 1'b0;
    case (ph)
      PH_CMD: begin
        case (idx[1:0])
          2'd0: spi_tx_data = (op == OP_LOAD) ? OPC_LOAD : (op == OP_PROG) ? OPC_PROG : OPC_CMP;
          2'd1: spi_tx_data = flash_addr[23:16];
          2'd2: spi_tx_data = flash_addr[15:8];
          default: spi_tx_data = flash_addr[7:0];
        endcase
        spi_tx_last = (idx[1:0] == 2'd3) && (op != OP_PROG);
      end
      PH_DATA: begin
        spi_tx_data = wr_data;
        spi_tx_last = (idx == chunk - 1'b1);
      end
      default: begin
        spi_tx_data = idx[0] ? 8'h00 : OPC_STAT;
        spi_tx_last = idx[0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; waitrx <= 1'b0; op <= OP_LOAD; ph <= PH_CMD;
      idx <= '0; off <= '0; chunk <= '0; page <= '0; rem <= '0; written <= '0;
      done <= 1'b0; done_err_range <= 1'b0; done_err_verify <= 1'b0; done_count <= '0;
    end else begin
      done <= 1'b0;
      if (fire) waitrx <= 1'b1;
      if (!busy) begin
        if (req_valid) begin
          written <= '0;
          if (req_end > cfg_dev_bytes) begin
            done <= 1'b1; done_err_range <= 1'b1; done_err_verify <= 1'b0; done_count <= '0;
          end else if (req_len == '0) begin
            done <= 1'b1; done_err_range <= 1'b0; done_err_verify <= 1'b0; done_count <= '0;
          end else begin
            busy  <= 1'b1;
            page  <= start_page;
            off   <= start_off;
            chunk <= first_chunk;
            rem   <= req_len;
            op    <= (first_chunk != cfg_page_size) ? OP_LOAD : OP_PROG;
            ph    <= PH_CMD;
            idx   <= '0;
          end
        end
      end else if (step) begin
        waitrx <= 1'b0;
        case (ph)
          PH_CMD:
            if (idx[1:0] == 2'd3) begin
              ph  <= (op == OP_PROG) ? PH_DATA : PH_STAT;
              idx <= '0;
            end else idx <= idx + 1'b1;
          PH_DATA:
            if (idx == chunk - 1'b1) begin
              ph  <= PH_STAT;
              idx <= '0;
            end else idx <= idx + 1'b1;
          default:
            if (!idx[0]) idx <= idx + 1'b1;
            else if (!spi_rx_data[7]) idx <= '0;
            else if (op == OP_LOAD) begin
              op <= OP_PROG; ph <= PH_CMD; idx <= '0;
            end else if (op == OP_PROG && cfg_verify) begin
              op <= OP_CMP; ph <= PH_CMD; idx <= '0;
            end else if (op == OP_CMP && spi_rx_data[6]) begin
              busy <= 1'b0; done <= 1'b1;
              done_err_range <= 1'b0; done_err_verify <= 1'b1; done_count <= written;
            end
        endcase
        if (page_ok) begin
          written <= written + AW'(chunk);
          rem     <= rem_after;
          if (rem_after == '0) begin
            busy <= 1'b0; done <= 1'b1;
            done_err_range <= 1'b0; done_err_verify <= 1'b0;
            done_count <= written + AW'(chunk);
          end else begin
            page  <= page + 1'b1;
            off   <= '0;
            chunk <= next_chunk;
            op    <= (next_chunk != cfg_page_size) ? OP_LOAD : OP_PROG;
            ph    <= PH_CMD;
            idx   <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          done_err_range,
  input logic          done_err_verify,
  input logic [AW-1:0] done_count,
  input logic          spi_tx_valid,
  input logic          spi_tx_ready,
  input logic [7:0]    spi_tx_data,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [7:0]    wr_data
);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r2_range_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err_range) |-> (done_count == '0 && !done_err_verify));

  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!spi_tx_valid && !wr_ready));

  a_r8_stream_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (spi_tx_valid && spi_tx_data == wr_data));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && spi_tx_ready) |=> !spi_tx_valid);
endmodule

bind flash_page_writer flash_page_writer_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .done_err_range(done_err_range), .done_err_verify(done_err_verify),
  .done_count(done_count), .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
  .spi_tx_data(spi_tx_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
);

// File: tb/flash_page_writer_tb_top.sv
module flash_page_writer_tb_top;
  localparam int AW = 24, PW = 12;
  localparam int PS = 8, NP = 4, DEV = PS * NP;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready, cfg_verify = 1'b0;
  logic [AW-1:0] req_offset = '0, req_len = '0;
  logic [7:0] wr_data, spi_tx_data, spi_rx_data;
  logic wr_valid, wr_ready, spi_tx_last, spi_tx_valid, spi_tx_ready, spi_rx_valid;
  logic done, done_err_range, done_err_verify;
  logic [AW-1:0] done_count;

  flash_page_writer #(.AW(AW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .cfg_page_size(PW'(PS)),
    .cfg_page_shift(5'd8), .cfg_dev_bytes((AW+1)'(DEV)), .cfg_verify(cfg_verify),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .spi_tx_data(spi_tx_data), .spi_tx_last(spi_tx_last), .spi_tx_valid(spi_tx_valid),
    .spi_tx_ready(spi_tx_ready), .spi_rx_data(spi_rx_data), .spi_rx_valid(spi_rx_valid),
    .done(done), .done_err_range(done_err_range), .done_err_verify(done_err_verify),
    .done_count(done_count)
  );

  function automatic logic [7:0] dval(int s, int i);
    return 8'(s * 29 + i * 13 + 7);
  endfunction

  int cyc = 0, wcnt = 0, wbase = 0, seed = 0, corrupt_page = -1;
  int n_load = 0, n_cmp = 0, n_bytes = 0, n_gate_bad = 0, n_busy_bad = 0, n_addr_bad = 0, n_r9_bad = 0;
  bit hung = 1'b0, fired_prev = 1'b0;
  int errors = 0, checks = 0;

  logic [7:0] mem [DEV];
  logic [7:0] fbuf [PS];
  logic [7:0] refm [DEV];
  int pos = 0, busy_cnt = 0;
  logic [7:0] mop = 8'h00;
  logic [23:0] maddr = '0;
  bit mism = 1'b0;

  assign wr_valid = (cyc % 5) != 2;
  assign wr_data  = dval(seed, wcnt - wbase);

  always @(posedge clk) begin
    int pg;
    logic [7:0] b, resp;
    bit same;
    cyc <= cyc + 1;
    if (cyc > 190000) hung <= 1'b1;
    spi_rx_valid <= 1'b0;
    spi_tx_ready <= (cyc % 4) != 3;
    if (!rst_n) begin
      for (int k = 0; k < DEV; k++) mem[k] = 8'(k * 3 + 1);
      pos = 0; busy_cnt = 0; mism = 1'b0; fired_prev = 1'b0;
      spi_rx_data <= 8'h00;
    end else begin
      if (wr_valid && wr_ready) begin
        wcnt <= wcnt + 1;
        if (!(spi_tx_valid && spi_tx_ready)) n_gate_bad++;
      end
      if (spi_tx_valid && spi_tx_ready) begin
        if (fired_prev) n_r9_bad++;
        b = spi_tx_data; resp = 8'h00; n_bytes++;
        if (pos == 0) begin
          mop = b;
          if (b != 8'hD7 && busy_cnt != 0) n_busy_bad++;
        end else if (pos < 4) maddr = {maddr[15:0], b};
        if (mop == 8'h82 && pos >= 4) begin
          if (!(wr_valid && wr_ready) || b != wr_data) n_gate_bad++;
          fbuf[(32'(maddr[7:0]) + pos - 4) % PS] = b;
        end else if (wr_valid && wr_ready) n_gate_bad++;
        if (mop == 8'hD7 && pos == 1) begin
          resp = {busy_cnt == 0, mism, 6'b0};
          if (busy_cnt > 0) busy_cnt--;
        end
        if (spi_tx_last) begin
          pg = 32'(maddr >> 8) % NP;
          case (mop)
            8'h53: begin
              if (maddr[7:0] != 8'h00) n_addr_bad++;
              for (int k = 0; k < PS; k++) fbuf[k] = mem[pg*PS+k];
              n_load++; busy_cnt = 2;
            end
            8'h82: begin
              for (int k = 0; k < PS; k++) mem[pg*PS+k] = fbuf[k];
              if (pg == corrupt_page) mem[pg*PS] = mem[pg*PS] ^ 8'h5A;
              busy_cnt = 2;
            end
            8'h60: begin
              if (maddr[7:0] != 8'h00) n_addr_bad++;
              same = 1'b1;
              for (int k = 0; k < PS; k++) if (mem[pg*PS+k] != fbuf[k]) same = 1'b0;
              mism = !same; n_cmp++; busy_cnt = 2;
            end
            default: ;
          endcase
          pos = 0;
        end else pos++;
        spi_rx_valid <= 1'b1;
        spi_rx_data  <= resp;
        fired_prev = 1'b1;
      end else fired_prev = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int o, input int len, input bit v, input int cp);
    int b_load, b_cmp, b_bytes, b_gate, b_busy, b_addr, b_r9, b_w;
    int exp_load, exp_cmp, exp_cnt, cnt, pg, of, r, ch, i, bad;
    bit exp_range, exp_ver;
    if (hung) return;
    @(negedge clk);
    b_load = n_load; b_cmp = n_cmp; b_bytes = n_bytes; b_gate = n_gate_bad;
    b_busy = n_busy_bad; b_addr = n_addr_bad; b_r9 = n_r9_bad; b_w = wcnt;
    seed = o * 5 + len + (v ? 100 : 0); wbase = wcnt;
    corrupt_page = cp; cfg_verify = v;
    req_offset = AW'(o); req_len = AW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && !hung) @(negedge clk);
    if (hung) return;

    exp_load = 0; exp_cmp = 0; cnt = 0; exp_ver = 1'b0;
    exp_range = (o + len) > DEV;
    if (!exp_range) begin
      pg = o / PS; of = o % PS; r = len; i = 0;
      while (r > 0) begin
        ch = (r < PS - of) ? r : PS - of;
        if (ch != PS) exp_load++;
        for (int k = 0; k < ch; k++) begin refm[pg*PS+of+k] = dval(seed, i); i++; end
        if (v) exp_cmp++;
        if (pg == cp) begin
          refm[pg*PS] = refm[pg*PS] ^ 8'h5A;
          if (v) begin exp_ver = 1'b1; break; end
        end
        cnt += ch; r -= ch; pg++; of = 0;
      end
    end
    exp_cnt = exp_range ? 0 : cnt;

    chk(done_err_range == exp_range, "R2", "range flag", int'(done_err_range), int'(exp_range));
    chk(done_err_verify == exp_ver, "R7", "verify flag", int'(done_err_verify), int'(exp_ver));
    chk(int'(done_count) == exp_cnt, exp_ver ? "R7" : "R1", "byte count", int'(done_count), exp_cnt);
    chk(n_load - b_load == exp_load, "R3", "buffer-load frames", n_load - b_load, exp_load);
    chk(n_cmp - b_cmp == exp_cmp, "R7", "compare frames", n_cmp - b_cmp, exp_cmp);
    chk(n_addr_bad == b_addr, "R4", "page address low byte nonzero", n_addr_bad - b_addr, 0);
    chk(n_busy_bad == b_busy, "R6", "command while device busy", n_busy_bad - b_busy, 0);
    chk(n_gate_bad == b_gate, "R8", "stream outside data phase", n_gate_bad - b_gate, 0);
    chk(n_r9_bad == b_r9, "R9", "back-to-back bytes", n_r9_bad - b_r9, 0);
    if (exp_range || len == 0) begin
      chk(n_bytes == b_bytes, exp_range ? "R2" : "R1", "SPI bytes sent", n_bytes - b_bytes, 0);
      chk(wcnt == b_w, "R2", "stream bytes taken", wcnt - b_w, 0);
    end
    bad = 0;
    for (int k = 0; k < DEV; k++) if (mem[k] != refm[k]) bad++;
    chk(bad == 0, "R5", "flash bytes differing", bad, 0);
  endtask

  initial begin
    int lens [8];
    for (int k = 0; k < DEV; k++) refm[k] = 8'(k * 3 + 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(spi_tx_valid == 1'b0 && wr_ready == 1'b0, "R1", "idle outputs after reset",
        int'(spi_tx_valid) + int'(wr_ready), 0);

    for (int o = 0; o < DEV; o++) begin
      lens = '{0, 1, 3, 8, 9, 17, DEV - o, DEV - o + 1};
      for (int k = 0; k < 8; k++) run(o, lens[k], ((o + k) % 2) == 1, -1);
    end

    run(0, 24, 1'b1, 1);
    run(3, 20, 1'b1, 0);
    run(5, 20, 1'b1, 3);
    run(8, 8, 1'b1, 1);
    run(2, 12, 1'b0, 1);
    run(0, DEV, 1'b1, -1);

    if (hung) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule